// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block walks a software-loaded table of DDR2 initialization steps and emits them, one clock-wide command at a time, on a memory command/address bus. Each table slot holds an enable flag, a command kind (no-operation, precharge-all, refresh or mode-register set), a bank field that names the mode register, a data field for the address pins, and a wait count. After each command the block idles for the wait count in clock cycles before it moves on. Software fills the slots, writes the execute code to the control register, and polls the status register until the sequence reports complete.

The command order and all timing come from the table, not from hard-wired states. A typical load is a long no-operation settle, a precharge-all, the four mode-register writes with a DLL reset on the last one, a second precharge-all, four refreshes, a mode-register write without DLL reset, and an off-chip-driver calibration enter and exit. The memory controller enable bit can be set only once the sequence has reported complete, and the traffic-permitted output further waits for an external delay-line calibration flag.

Top module: `ddr2_init_seq`

## Requirements
- R1: The table has 16 slots at register addresses 0 to 15. A slot word has wait count in bits [7:0], data in bits [20:8], bank select in bits [22:21], command kind in bits [24:23] (0 no-operation, 1 precharge-all, 2 refresh, 3 mode-register set) and the enable flag in bit 25; a slot reads back as written.
- R2: Writing 2'b10 to bits [1:0] of the control register (address 16) while idle starts a walk; busy rises at that write edge and the first enabled slot's command is driven on the next clock.
- R3: Slots are processed in ascending index order; only slots with the enable flag set issue a command, and disabled slots cost no cycles.
- R4: Each command is valid for exactly one clock; a slot with wait W is followed by the next command W+1 clocks later, so W = 0 gives back-to-back commands.
- R5: Pins {cs_n, ras_n, cas_n, we_n} are 0111 for no-operation, 0010 for precharge-all, 0001 for refresh, 0000 for mode-register set, and 1111 (deselect) whenever no command is valid.
- R6: The bank output carries the slot's bank select and the address output carries the slot's data field, with address bit 10 forced high on precharge-all.
- R7: Complete is raised and busy dropped W+1 clocks after the last command (one clock after the start edge when no slot is enabled); status at address 16 reads bit 0 busy, bit 1 complete, bit 2 controller enable, bit 3 delay-line flag.
- R8: Complete stays set until reset or until the next accepted start, which clears it at the start edge.
- R9: Slot writes and start writes issued while busy are ignored.
- R10: Writing the control register sets the controller enable from bit 2 only if complete is already set; otherwise it is cleared, and an accepted start also clears it.
- R11: Traffic is permitted only while the controller enable is set and the delay-line calibration input is high.
- R12: After reset all slots are zero, no command is valid, the pins are deselected, and busy, complete, enable and traffic-permitted are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address: slots 0-15, control/status 16 |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| dl_cal_done_i | input | 1 | Delay-line calibration complete flag |
| cmd_valid_o | output | 1 | A command is driven this cycle |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address / mode-register select |
| addr_o | output | 13 | Address pins |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete |
| mc_en_o | output | 1 | Controller enable |
| traffic_ok_o | output | 1 | Normal traffic permitted |

## Verification
The bench builds the block with its defaults: 16 slots, 8-bit waits and a 32-bit register port, so the full power-up load with its 200-cycle DLL wait fits in one walk and the last slot index 15 is reachable. It logs every command with its cycle number and compares the order, pins, bank, address and spacing with values derived from the loaded table. Sparse tables with zero waits reach the back-to-back and skipped-slot cases, and an all-disabled table reaches the one-cycle completion path.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int WAIT_W = 8;
  localparam int CMD_W  = 2;
  localparam int AP_BIT = 10;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } cmd_e;

  typedef struct packed {
    logic              en;
    cmd_e              cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] data;
    logic [WAIT_W-1:0] wait_cyc;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);
  localparam logic [1:0] EXEC_CODE = 2'b10;
endpackage

// File: rtl/ddr2_slot_table.sv
`timescale 1ns/1ps
module ddr2_slot_table
  import ddr2_init_pkg::*;
#(
  parameter  int NUM_SLOTS = 16,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  slot_t                   wr_slot_i,
  input  logic                    lock_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output slot_t                   rd_slot_o,
  output slot_t [NUM_SLOTS-1:0]   slots_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slots_o[g] <= '0;
      end else if (wr_en_i && !lock_i && (wr_idx_i == IDX_W'(g))) begin
        slots_o[g] <= wr_slot_i;
      end
    end
  end

  assign rd_slot_o = slots_o[rd_idx_i];

  // R9
  table_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(slots_o));
endmodule

// File: rtl/ddr2_init_walker.sv
`timescale 1ns/1ps
module ddr2_init_walker
  import ddr2_init_pkg::*;
#(
  parameter  int NUM_SLOTS = 16,
  localparam int PTR_W     = $clog2(NUM_SLOTS) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  slot_t [NUM_SLOTS-1:0] slots_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  issue_vld_o,
  output slot_t                 issue_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e               st_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              done_q;
  logic              vld_q;
  slot_t             iss_q;
  logic              found;
  logic [PTR_W-1:0]  nxt;
  slot_t             nxt_slot;

  // first enabled slot at or above the pointer
  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slots_i[i].en && (PTR_W'(i) >= ptr_q)) begin
        found = 1'b1;
        nxt   = PTR_W'(i);
      end
    end
  end

  assign nxt_slot = slots_i[nxt[PTR_W-2:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      iss_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_RUN;
            ptr_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (found) begin
            vld_q <= 1'b1;
            iss_q <= nxt_slot;
            cnt_q <= nxt_slot.wait_cyc;
            ptr_q <= nxt + 1'b1;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q == ST_RUN);
  assign done_o      = done_q;
  assign issue_vld_o = vld_q;
  assign issue_o     = iss_q;

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o);
  // R3
  en_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o |-> issue_o.en && busy_o);
  // R4
  cmd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o && (issue_o.wait_cyc != '0) |=> !issue_vld_o);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
endmodule

// File: rtl/ddr2_cmd_encode.sv
`timescale 1ns/1ps
module ddr2_cmd_encode
  import ddr2_init_pkg::*;
(
  input  logic              vld_i,
  input  slot_t             slot_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic unused_w;
  assign unused_w = slot_i.en ^ (^slot_i.wait_cyc);

  always_comb begin
    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b1111;
    ba_o   = '0;
    addr_o = '0;
    if (vld_i) begin
      ba_o   = slot_i.ba;
      addr_o = slot_i.data;
      unique case (slot_i.cmd)
        CMD_NOP: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
        CMD_PRE: begin
          {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0010;
          addr_o[AP_BIT] = 1'b1;
        end
        CMD_REF: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0001;
        CMD_MRS: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0000;
        default: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b1111;
      endcase
    end
  end
endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter  int NUM_SLOTS = 16,
  parameter  int REG_W     = 32,
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int RADDR_W   = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [RADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               dl_cal_done_i,
  output logic               cmd_valid_o,
  output logic               cs_n_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               we_n_o,
  output logic [BA_W-1:0]    ba_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               mc_en_o,
  output logic               traffic_ok_o
);
  localparam logic [RADDR_W-1:0] CTRL_ADDR = RADDR_W'(NUM_SLOTS);

  logic                  slot_sel, ctrl_sel, start;
  logic                  busy, done, mc_en_q;
  slot_t                 rd_slot, issue;
  logic                  issue_vld;
  slot_t [NUM_SLOTS-1:0] slots;
  logic                  unused_w;

  assign unused_w = ^reg_wdata_i[REG_W-1:SLOT_W];
  assign slot_sel = reg_addr_i < CTRL_ADDR;
  assign ctrl_sel = reg_addr_i == CTRL_ADDR;
  assign start    = reg_we_i && ctrl_sel && (reg_wdata_i[1:0] == EXEC_CODE) && !busy;

  ddr2_slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_we_i && slot_sel),
    .wr_idx_i  (reg_addr_i[IDX_W-1:0]),
    .wr_slot_i (slot_t'(reg_wdata_i[SLOT_W-1:0])),
    .lock_i    (busy),
    .rd_idx_i  (reg_addr_i[IDX_W-1:0]),
    .rd_slot_o (rd_slot),
    .slots_o   (slots)
  );

  ddr2_init_walker #(.NUM_SLOTS(NUM_SLOTS)) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .slots_i     (slots),
    .busy_o      (busy),
    .done_o      (done),
    .issue_vld_o (issue_vld),
    .issue_o     (issue)
  );

  ddr2_cmd_encode u_enc (
    .vld_i   (issue_vld),
    .slot_i  (issue),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  // controller enable only once the walk has completed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_en_q <= 1'b0;
    end else if (start) begin
      mc_en_q <= 1'b0;
    end else if (reg_we_i && ctrl_sel) begin
      mc_en_q <= reg_wdata_i[2] && done;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (slot_sel)      reg_rdata_o = REG_W'(rd_slot);
    else if (ctrl_sel) reg_rdata_o = REG_W'({dl_cal_done_i, mc_en_q, done, busy});
  end

  assign cmd_valid_o  = issue_vld;
  assign busy_o       = busy;
  assign done_o       = done;
  assign mc_en_o      = mc_en_q;
  assign traffic_ok_o = mc_en_q && dl_cal_done_i;

  // R10
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mc_en_o) |-> $past(done_o));
  // R10
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !mc_en_o);
  // R5
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> cs_n_o && ras_n_o && cas_n_o && we_n_o);
endmodule

// File: tb/ddr2_init_seq_bench.sv
`timescale 1ns/1ps
module ddr2_init_seq_bench;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dl_cal = 1'b0;
  logic        cmd_valid, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] a;
  logic        busy, done, mc_en, traffic_ok;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_log = 0;
  int bad_desel = 0;
  int log_cyc [256];
  int log_cmd [256];
  int log_ba  [256];
  int log_addr[256];

  bit t_en   [NS];
  int t_cmd  [NS];
  int t_ba   [NS];
  int t_data [NS];
  int t_wait [NS];

  always #10 clk = ~clk;

  ddr2_init_seq u_ddr2_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .dl_cal_done_i(dl_cal),
    .cmd_valid_o(cmd_valid), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .ba_o(ba), .addr_o(a), .busy_o(busy), .done_o(done),
    .mc_en_o(mc_en), .traffic_ok_o(traffic_ok)
  );

  function automatic int dec(input logic [3:0] p);
    case (p)
      4'b0111: return 0;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 9;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cmd_valid && n_log < 256) begin
      log_cyc[n_log]  = cyc;
      log_cmd[n_log]  = dec({cs_n, ras_n, cas_n, we_n});
      log_ba[n_log]   = int'(ba);
      log_addr[n_log] = int'(a);
      n_log = n_log + 1;
    end
    if (rst_n && !cmd_valid && {cs_n, ras_n, cas_n, we_n} != 4'b1111)
      bad_desel = bad_desel + 1;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int s);
    return {6'd0, t_en[s], t_cmd[s][1:0], t_ba[s][1:0], t_data[s][12:0], t_wait[s][7:0]};
  endfunction

  task automatic wr(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = ad; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ad, output logic [31:0] d);
    @(negedge clk);
    addr = ad;
    #1 d = rdata;
  endtask

  task automatic set_slot(input int s, input bit en, input int c, input int b, input int d, input int w);
    t_en[s] = en; t_cmd[s] = c; t_ba[s] = b; t_data[s] = d; t_wait[s] = w;
  endtask

  task automatic clear_tbl();
    for (int s = 0; s < NS; s++) set_slot(s, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic load_tbl();
    for (int s = 0; s < NS; s++) wr(5'(s), word(s));
  endtask

  task automatic start_seq(output int sc);
    wr(5'd16, 32'h2);
    sc = cyc;
  endtask

  task automatic wait_done(output int dc);
    dc = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin
        dc = cyc;
        break;
      end
    end
  endtask

  task automatic verify_run(input int base, input int sc, input int dc);
    int exp_c = sc + 1;
    int k = base;
    int ea;
    for (int s = 0; s < NS; s++) begin
      if (t_en[s]) begin
        ea = (t_cmd[s] == 1) ? (t_data[s] | 32'h400) : t_data[s];
        if (k < n_log) begin
          chk(log_cmd[k] == t_cmd[s], "R3 R5 command kind in order", log_cmd[k], t_cmd[s]);
          chk(log_ba[k] == t_ba[s], "R6 bank select", log_ba[k], t_ba[s]);
          chk(log_addr[k] == ea, "R6 address field", log_addr[k], ea);
          chk(log_cyc[k] == exp_c, "R4 command spacing", log_cyc[k], exp_c);
        end else begin
          chk(1'b0, "R3 missing command", n_log, k + 1);
        end
        exp_c = exp_c + t_wait[s] + 1;
        k++;
      end
    end
    chk(n_log == k, "R3 command count", n_log, k);
    chk(dc == exp_c, "R7 completion cycle", dc, exp_c);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    dl_cal = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && cs_n && ras_n && cas_n && we_n, "R12 pins idle after reset",
        {cmd_valid, cs_n, ras_n, cas_n, we_n}, 5'b01111);
    chk(!busy && !done && !mc_en && !traffic_ok, "R12 status low after reset",
        {busy, done, mc_en, traffic_ok}, 0);
    rd(5'd0, d);
    chk(d == 0, "R12 slot cleared", d, 0);
    rd(5'd16, d);
    chk(d == 32'h8, "R7 status word after reset", d, 32'h8);
    dl_cal = 1'b0;
  endtask

  task automatic test_enable_early();
    logic [31:0] d;
    wr(5'd16, 32'h4);
    @(negedge clk);
    chk(!mc_en, "R10 enable refused before completion", mc_en, 0);
    rd(5'd16, d);
    chk(d[2] == 1'b0, "R10 status enable bit", d[2], 0);
  endtask

  task automatic test_full_seq();
    int sc, dc, base;
    logic [31:0] d;
    int mr = 13'h0432;
    int emr = 13'h0044;
    clear_tbl();
    set_slot(0, 1, 0, 0, 0, 106);
    set_slot(1, 1, 1, 0, 0, 4);
    set_slot(2, 1, 3, 2, 0, 2);
    set_slot(3, 1, 3, 3, 0, 2);
    set_slot(4, 1, 3, 1, emr, 2);
    set_slot(5, 1, 3, 0, mr | 13'h100, 200);
    set_slot(6, 1, 1, 0, 0, 4);
    for (int s = 7; s < 11; s++) set_slot(s, 1, 2, 0, 0, 25);
    set_slot(11, 1, 3, 0, mr, 2);
    set_slot(12, 1, 3, 1, emr | 13'h380, 2);
    set_slot(13, 1, 3, 1, emr, 2);
    load_tbl();
    rd(5'd5, d);
    chk(d == word(5), "R1 slot readback", d, word(5));
    base = n_log;
    start_seq(sc);
    chk(busy && !done, "R2 busy after start", {busy, done}, 2'b10);
    wait_done(dc);
    verify_run(base, sc, dc);
    chk(!busy, "R7 busy dropped at completion", busy, 0);
    rd(5'd16, d);
    chk(d[1:0] == 2'b10, "R7 status complete", d[1:0], 2'b10);
  endtask

  task automatic test_enable_after();
    logic [31:0] d;
    wr(5'd16, 32'h4);
    @(negedge clk);
    chk(mc_en, "R10 enable accepted after completion", mc_en, 1);
    chk(!traffic_ok, "R11 traffic blocked without calibration", traffic_ok, 0);
    dl_cal = 1'b1;
    #1;
    chk(traffic_ok, "R11 traffic allowed with calibration", traffic_ok, 1);
    repeat (50) @(negedge clk);
    chk(done, "R8 completion held while idle", done, 1);
    rd(5'd16, d);
    chk(d[3:0] == 4'b1110, "R7 status bits", d[3:0], 4'b1110);
  endtask

  task automatic test_sparse();
    int sc, dc, base;
    clear_tbl();
    set_slot(1, 1, 1, 0, 13'h0123, 0);
    set_slot(2, 1, 2, 1, 13'h0007, 0);
    set_slot(5, 1, 3, 2, 13'h01AB, 3);
    set_slot(15, 1, 0, 3, 13'h1FFF, 0);
    set_slot(9, 0, 3, 1, 13'h0055, 9);
    load_tbl();
    base = n_log;
    start_seq(sc);
    chk(!done, "R8 completion cleared by start", done, 0);
    chk(!mc_en && !traffic_ok, "R10 start clears enable", {mc_en, traffic_ok}, 0);
    wait_done(dc);
    verify_run(base, sc, dc);
  endtask

  task automatic test_busy_ignore();
    int sc, dc, base;
    logic [31:0] d;
    clear_tbl();
    set_slot(0, 1, 0, 0, 0, 20);
    set_slot(1, 1, 2, 0, 0, 0);
    load_tbl();
    base = n_log;
    start_seq(sc);
    wr(5'd1, 32'h3FFFFFF);
    wr(5'd16, 32'h2);
    wait_done(dc);
    verify_run(base, sc, dc);
    rd(5'd1, d);
    chk(d == word(1), "R9 slot write ignored while busy", d, word(1));
  endtask

  task automatic test_none();
    int sc, dc, base;
    clear_tbl();
    set_slot(3, 0, 3, 1, 13'h0AAA, 5);
    load_tbl();
    base = n_log;
    start_seq(sc);
    wait_done(dc);
    verify_run(base, sc, dc);
    chk(bad_desel == 0, "R5 deselect between commands", bad_desel, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_enable_early();
    test_full_seq();
    test_enable_after();
    test_sparse();
    test_busy_ignore();
    test_none();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule